// File: doc/BRIEF.md
# Return-From-Exception Status Restorer

This block computes the processor status word and the stack-pointer pair that result from a return-from-exception or a return-from-NMI. The status word holds a small stack of mode fields: older fields live in higher bit groups, and a return pops that stack by shifting. The top two bits stay where they are. The two bits below them become zero. The remaining low field moves right by a fixed amount.

After the pop, the block sets the P flag unless the R flag was set in the word before the shift. The NMI variant also forces the M flag. When the popped word has the user-mode flag U set, the current stack pointer is saved as the kernel stack pointer and the user stack pointer becomes the live one.

The pipeline offers the current status word, the live, kernel and user stack pointers, a strobe and the return kind. All results are registered. They change on the clock edge that samples the strobe and hold otherwise.

Top module: `rfe_status_restore`

## Requirements
- R1: While reset (active low) is asserted, the status, stack-pointer and kernel-stack-pointer outputs are all zero.
- R2: On a strobe, the new status keeps old bits 31:30, clears bits 29:28, and places old bits 27:0 shifted right by 10 in bits 27:0 (zero-filled), before any flag is added.
- R3: On a strobe, if bit 8 (the R flag) of the old status is 0, bit 7 (the P flag) of the new status is 1. If R is 1, bit 7 is the popped value (old bit 17).
- R4: On a strobe with kind 1 (return-from-NMI), bit 30 (the M flag) of the new status is 1. With kind 0 (return-from-exception), bit 30 follows R2.
- R5: On a strobe, if bit 8 (the U flag) of the new status is 1, the new stack pointer takes the user stack pointer input and the new kernel stack pointer takes the current stack pointer input.
- R6: On a strobe where the new U flag is 0, the new stack pointer and new kernel stack pointer take the current stack pointer and kernel stack pointer inputs unchanged.
- R7: Without a strobe, all three outputs hold their values whatever the inputs do.
- R8: The flag positions and the shift amount are parameters. A build with U=5, P=3, R=12, M=31 and shift 8 follows R2 to R6 with those positions and that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | Return strobe, one cycle per operation |
| ret_kind | input | 1 | 0 = return-from-exception, 1 = return-from-NMI |
| cur_status | input | W | Status word before the return |
| cur_sp | input | AW | Live stack pointer before the return |
| cur_ksp | input | AW | Kernel stack pointer before the return |
| cur_usp | input | AW | User stack pointer |
| new_status | output | W | Registered status word after the return |
| new_sp | output | AW | Registered live stack pointer after the return |
| new_ksp | output | AW | Registered kernel stack pointer after the return |

## Verification
The bench builds two instances side by side from the same stimulus. One uses the default parameters. The other moves U to bit 5, P to bit 3, R to bit 12 and M to bit 31, and shifts by 8. The second build catches a flag or shift that is hardwired instead of taken from its parameter. It also places M in the top bit of the kept pair, where RFN must override a kept zero. Both builds get directed words (all zeros, all ones, R alone, U alone) and random words, with random strobe gaps in between.

// File: rtl/rfe_status_pkg.sv
package rfe_status_pkg;

  typedef enum logic {
    RET_EXC = 1'b0,
    RET_NMI = 1'b1
  } ret_kind_e;

  // Single-bit mask at a given position of a word
  function automatic logic [63:0] bit_mask(input int unsigned pos);
    logic [63:0] m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/rfe_pop_shift.sv
module rfe_pop_shift #(
  parameter int unsigned W     = 32,
  parameter int unsigned KEEP  = 2,
  parameter int unsigned GAP   = 2,
  parameter int unsigned SHIFT = 10
) (
  input  logic [W-1:0] old_word,
  output logic [W-1:0] popped
);
  localparam int unsigned LOW = W - KEEP - GAP;

  logic [LOW-1:0] low_field;

  always_comb begin
    low_field = old_word[LOW-1:0] >> SHIFT;
  end

  generate
    if (GAP > 0) begin : g_gap
      always_comb begin
        popped = {old_word[W-1 -: KEEP], {GAP{1'b0}}, low_field};
      end
    end else begin : g_nogap
      always_comb begin
        popped = {old_word[W-1 -: KEEP], low_field};
      end
    end
  endgenerate

endmodule

// File: rtl/rfe_flag_merge.sv
module rfe_flag_merge #(
  parameter int unsigned W     = 32,
  parameter int unsigned P_POS = 7,
  parameter int unsigned M_POS = 30
) (
  input  logic [W-1:0] popped,
  input  logic         old_r,
  input  logic         is_nmi,
  output logic [W-1:0] merged
);
  import rfe_status_pkg::*;

  localparam logic [63:0] P_MASK64 = bit_mask(P_POS);
  localparam logic [63:0] M_MASK64 = bit_mask(M_POS);
  localparam logic [W-1:0] P_MASK  = P_MASK64[W-1:0];
  localparam logic [W-1:0] M_MASK  = M_MASK64[W-1:0];

  logic [W-1:0] p_add;
  logic [W-1:0] m_add;

  always_comb begin
    p_add  = old_r  ? '0 : P_MASK;
    m_add  = is_nmi ? M_MASK : '0;
    merged = popped | p_add | m_add;
  end

endmodule

// File: rtl/rfe_sp_select.sv
module rfe_sp_select #(
  parameter int unsigned AW = 32
) (
  input  logic          user_mode,
  input  logic [AW-1:0] cur_sp,
  input  logic [AW-1:0] cur_ksp,
  input  logic [AW-1:0] cur_usp,
  output logic [AW-1:0] sp_out,
  output logic [AW-1:0] ksp_out
);

  always_comb begin
    if (user_mode) begin
      sp_out  = cur_usp;
      ksp_out = cur_sp;
    end else begin
      sp_out  = cur_sp;
      ksp_out = cur_ksp;
    end
  end

endmodule

// File: rtl/rfe_status_restore.sv
module rfe_status_restore #(
  parameter int unsigned W     = 32,
  parameter int unsigned AW    = 32,
  parameter int unsigned KEEP  = 2,
  parameter int unsigned GAP   = 2,
  parameter int unsigned SHIFT = 10,
  parameter int unsigned U_POS = 8,
  parameter int unsigned P_POS = 7,
  parameter int unsigned R_POS = 8,
  parameter int unsigned M_POS = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ret_valid,
  input  logic          ret_kind,
  input  logic [W-1:0]  cur_status,
  input  logic [AW-1:0] cur_sp,
  input  logic [AW-1:0] cur_ksp,
  input  logic [AW-1:0] cur_usp,
  output logic [W-1:0]  new_status,
  output logic [AW-1:0] new_sp,
  output logic [AW-1:0] new_ksp
);
  import rfe_status_pkg::*;

  logic [W-1:0]  popped;
  logic [W-1:0]  merged;
  logic [AW-1:0] sp_sel;
  logic [AW-1:0] ksp_sel;
  logic          is_nmi;

  logic [W-1:0]  status_q, status_d;
  logic [AW-1:0] sp_q, sp_d;
  logic [AW-1:0] ksp_q, ksp_d;

  always_comb begin
    is_nmi = (ret_kind_e'(ret_kind) == RET_NMI);
  end

  rfe_pop_shift #(
    .W(W), .KEEP(KEEP), .GAP(GAP), .SHIFT(SHIFT)
  ) u_pop (
    .old_word (cur_status),
    .popped   (popped)
  );

  rfe_flag_merge #(
    .W(W), .P_POS(P_POS), .M_POS(M_POS)
  ) u_flags (
    .popped (popped),
    .old_r  (cur_status[R_POS]),
    .is_nmi (is_nmi),
    .merged (merged)
  );

  rfe_sp_select #(
    .AW(AW)
  ) u_sp (
    .user_mode (merged[U_POS]),
    .cur_sp    (cur_sp),
    .cur_ksp   (cur_ksp),
    .cur_usp   (cur_usp),
    .sp_out    (sp_sel),
    .ksp_out   (ksp_sel)
  );

  // Next-state: commit only on the strobe
  always_comb begin
    status_d = status_q;
    sp_d     = sp_q;
    ksp_d    = ksp_q;
    if (ret_valid) begin
      status_d = merged;
      sp_d     = sp_sel;
      ksp_d    = ksp_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      sp_q     <= '0;
      ksp_q    <= '0;
    end else begin
      status_q <= status_d;
      sp_q     <= sp_d;
      ksp_q    <= ksp_d;
    end
  end

  assign new_status = status_q;
  assign new_sp     = sp_q;
  assign new_ksp    = ksp_q;

endmodule

// File: rtl/rfe_status_restore_chk.sv
module rfe_status_restore_chk #(
  parameter int unsigned W     = 32,
  parameter int unsigned AW    = 32,
  parameter int unsigned KEEP  = 2,
  parameter int unsigned GAP   = 2,
  parameter int unsigned U_POS = 8,
  parameter int unsigned P_POS = 7,
  parameter int unsigned R_POS = 8,
  parameter int unsigned M_POS = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ret_valid,
  input logic          ret_kind,
  input logic [W-1:0]  cur_status,
  input logic [AW-1:0] cur_sp,
  input logic [AW-1:0] cur_ksp,
  input logic [AW-1:0] cur_usp,
  input logic [W-1:0]  new_status,
  input logic [AW-1:0] new_sp,
  input logic [AW-1:0] new_ksp
);
  localparam int unsigned GAP_LO = W - KEEP - GAP;

  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_r1: assert (new_status == '0 && new_sp == '0 && new_ksp == '0)
        else $error("reset state not zero");
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> ($stable(new_status) && $stable(new_sp) && $stable(new_ksp)));

  generate
    if (GAP > 0) begin : g_gapchk
      p_gap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> (new_status[GAP_LO +: GAP] == '0));
    end
  endgenerate

  p_pflag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !cur_status[R_POS]) |=> new_status[P_POS]);

  p_mflag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_kind) |=> new_status[M_POS]);

  p_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> (!new_status[U_POS] ||
                   (new_sp == $past(cur_usp) && new_ksp == $past(cur_sp))));

  p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> (new_status[U_POS] ||
                   (new_sp == $past(cur_sp) && new_ksp == $past(cur_ksp))));

endmodule

bind rfe_status_restore rfe_status_restore_chk #(
  .W(W), .AW(AW), .KEEP(KEEP), .GAP(GAP),
  .U_POS(U_POS), .P_POS(P_POS), .R_POS(R_POS), .M_POS(M_POS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_kind(ret_kind),
  .cur_status(cur_status), .cur_sp(cur_sp), .cur_ksp(cur_ksp),
  .cur_usp(cur_usp), .new_status(new_status), .new_sp(new_sp),
  .new_ksp(new_ksp)
);

// File: tb/rfe_status_restore_tb.sv
`timescale 1ns/1ps
module rfe_status_restore_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ret_valid;
  logic        ret_kind;
  logic [31:0] cur_status, cur_sp, cur_ksp, cur_usp;
  logic [31:0] st_a, sp_a, ksp_a;
  logic [31:0] st_b, sp_b, ksp_b;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  rfe_status_restore u_dut (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_kind(ret_kind),
    .cur_status(cur_status), .cur_sp(cur_sp), .cur_ksp(cur_ksp),
    .cur_usp(cur_usp), .new_status(st_a), .new_sp(sp_a), .new_ksp(ksp_a)
  );

  rfe_status_restore #(
    .SHIFT(8), .U_POS(5), .P_POS(3), .R_POS(12), .M_POS(31)
  ) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_kind(ret_kind),
    .cur_status(cur_status), .cur_sp(cur_sp), .cur_ksp(cur_ksp),
    .cur_usp(cur_usp), .new_status(st_b), .new_sp(sp_b), .new_ksp(ksp_b)
  );

  function automatic logic [31:0] model_status(input logic [31:0] old,
      input logic kind, input int p, input int r, input int m, input int sh);
    logic [31:0] low;
    logic [31:0] res;
    low = {4'b0, old[27:0]} >> sh;
    res = {old[31:30], 2'b00, low[27:0]};
    if (!old[r]) res[p] = 1'b1;
    if (kind)    res[m] = 1'b1;
    return res;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic check_build(input string tag, input logic [31:0] old,
      input logic kind, input logic [31:0] sp, input logic [31:0] ksp,
      input logic [31:0] usp, input int u, input int p, input int r,
      input int m, input int sh, input logic [31:0] a_st,
      input logic [31:0] a_sp, input logic [31:0] a_ksp);
    logic [31:0] es;
    es = model_status(old, kind, p, r, m, sh);
    check({tag, " R2/R3/R4"}, "status", a_st, es);
    if (es[u]) begin
      check({tag, " R5"}, "sp", a_sp, usp);
      check({tag, " R5"}, "ksp", a_ksp, sp);
    end else begin
      check({tag, " R6"}, "sp", a_sp, sp);
      check({tag, " R6"}, "ksp", a_ksp, ksp);
    end
  endtask

  task automatic do_op(input logic [31:0] old, input logic kind,
      input logic [31:0] sp, input logic [31:0] ksp, input logic [31:0] usp);
    @(negedge clk);
    cur_status = old; ret_kind = kind;
    cur_sp = sp; cur_ksp = ksp; cur_usp = usp;
    ret_valid = 1'b1;
    @(negedge clk);
    ret_valid = 1'b0;
    check_build("dflt", old, kind, sp, ksp, usp, 8, 7, 8, 30, 10, st_a, sp_a, ksp_a);
    check_build("R8 alt", old, kind, sp, ksp, usp, 5, 3, 12, 31, 8, st_b, sp_b, ksp_b);
  endtask

  // R7: scramble inputs without strobe, outputs must hold
  task automatic hold_check(input int gap);
    logic [31:0] s0, p0, k0, s1, p1, k1;
    s0 = st_a; p0 = sp_a; k0 = ksp_a;
    s1 = st_b; p1 = sp_b; k1 = ksp_b;
    for (int i = 0; i < gap; i++) begin
      cur_status = $urandom; cur_sp = $urandom;
      cur_ksp = $urandom; cur_usp = $urandom; ret_kind = 1'($urandom);
      @(negedge clk);
    end
    check("R7", "status hold", st_a, s0);
    check("R7", "sp hold", sp_a, p0);
    check("R7", "ksp hold", ksp_a, k0);
    check("R7", "alt status hold", st_b, s1);
    check("R7", "alt sp hold", sp_b, p1);
    check("R7", "alt ksp hold", ksp_b, k1);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; ret_valid = 1'b0; ret_kind = 1'b0;
    cur_status = '1; cur_sp = 32'h1111; cur_ksp = 32'h2222; cur_usp = 32'h3333;
    repeat (3) @(negedge clk);
    check("R1", "status in reset", st_a, 32'h0);
    check("R1", "sp in reset", sp_a, 32'h0);
    check("R1", "ksp in reset", ksp_a, 32'h0);
    check("R1", "alt status in reset", st_b, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", "status idle after reset", st_a, 32'h0);

    // Directed corners
    do_op(32'h0000_0000, 1'b0, 32'hA000_0001, 32'hB000_0002, 32'hC000_0003);
    check("R3", "zero word RFE gives P", st_a, 32'h0000_0080);
    do_op(32'hFFFF_FFFF, 1'b0, 32'hA000_0011, 32'hB000_0012, 32'hC000_0013);
    check("R2", "all ones RFE", st_a, 32'hC003_FFFF);
    check("R5", "all ones swaps sp", sp_a, 32'hC000_0013);
    do_op(32'h0000_0100, 1'b0, 32'h1, 32'h2, 32'h3);
    check("R3", "R set suppresses P", st_a, 32'h0000_0000);
    do_op(32'h0000_0100, 1'b1, 32'h1, 32'h2, 32'h3);
    check("R4", "RFN forces M", st_a, 32'h4000_0000);
    do_op(32'h0004_0000, 1'b0, 32'h5, 32'h6, 32'h7);
    check("R5", "U only", st_a, 32'h0000_0180);
    check("R5", "ksp gets old sp", ksp_a, 32'h5);
    do_op(32'h4000_0000, 1'b0, 32'h8, 32'h9, 32'hA);
    check("R4", "RFE keeps bit 30", st_a, 32'h4000_0080);
    hold_check(3);

    for (int i = 0; i < 400; i++) begin
      do_op($urandom, 1'($urandom), $urandom, $urandom, $urandom);
      if (($urandom % 4) == 0) hold_check(1 + int'($urandom % 3));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule